// File: doc/BRIEF.md
# Write Burst Slot and Data Tracker

This block follows write address requests and the write data beats that belong to them, so that a delay model can see which beats of each burst are present and which have finished their simulated memory operation. Each accepted write address takes a free slot that records the internal identifier handed out for its response, the base address, the beat size, a fixed-address flag and three per-beat bit vectors: data present, memory operation pending and memory operation done.

Write data is never stalled. Beats may arrive before their address. A signed balance counter adds one for every beat and subtracts the burst length of every accepted address. When an address is accepted, a positive balance credits its first beats at once. Beats that arrive while the balance is negative go to the oldest slot still missing data. Slot age is kept in a triangular matrix. An outside scheduler reports completed beats one at a time. When every beat of a slot is done, the slot frees itself and raises a release flag for its internal identifier. A one-hot release notice clears that flag.

Top module: `wr_slot_tracker`

## Requirements
- R1: `w_ready_o` is 1 in every cycle, including during reset.
- R2: `aw_ready_o` is 1 exactly when at least one slot is free. An accepted address takes the lowest-numbered free slot, and that slot's bit in `slot_valid_o` is 1 after the accepting clock edge. A request made while all slots are full changes no slot.
- R3: The balance counter equals beats seen minus the sum of accepted burst lengths. A beat in the same cycle as an address is counted first. On acceptance, the immediate count is that balance clamped to the range 0..length, and data bits 0..imm-1 of the new slot are set.
- R4: On allocation, burst bits at index length and above have data and done set to 1. In-burst bits not covered by the immediate count have data 0 and done 0. All pending bits are 0.
- R5: A beat that arrives while the counter is negative sets the lowest clear data bit, and the matching pending bit, of the chosen slot.
- R6: The chosen slot is the earliest-accepted slot still valid that has a clear data bit.
- R7: A done report (`done_slot_i`, `done_beat_i`) is taken only if that slot is valid and that beat's data bit is 1. A taken report sets the done bit and clears the pending bit. Any other report changes nothing.
- R8: A valid slot whose done bits are all 1 is freed at the next clock edge. At the same edge, bit `iid` of `release_en_o` is set.
- R9: A 1 in bit k of the one-hot `released_iid_i` clears release flag k at the next edge. A set for the same flag in the same cycle wins over the clear.
- R10: `qry_addr_o` is combinational. For a slot marked fixed it is the base address. Otherwise it is base + beat·2^size, modulo 2^ADDR_W.
- R11: After reset, no slot is valid, no release flag is set and the balance is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aw_valid_i | input | 1 | Write address request present |
| aw_ready_o | output | 1 | A slot is free |
| aw_iid_i | input | IID_W | Internal identifier of the request |
| aw_addr_i | input | ADDR_W | Base address |
| aw_size_i | input | SIZE_W | log2 of bytes per beat |
| aw_fixed_i | input | 1 | Every beat uses the base address |
| aw_len_i | input | LEN_W | Beats in the burst, 1..MAX_BURST |
| w_valid_i | input | 1 | One write data beat |
| w_ready_o | output | 1 | Always 1 |
| done_valid_i | input | 1 | A beat's memory operation finished |
| done_slot_i | input | SLOT_W | Slot of the finished beat |
| done_beat_i | input | BEAT_W | Beat index within the slot |
| qry_slot_i | input | SLOT_W | Slot to query for a beat address |
| qry_beat_i | input | BEAT_W | Beat to query |
| qry_addr_o | output | ADDR_W | Address of the queried beat |
| slot_valid_o | output | NUM_SLOTS | Occupied slots |
| data_v_o | output | NUM_SLOTS*MAX_BURST | Data bits; slot s, beat b at s*MAX_BURST+b |
| pending_o | output | NUM_SLOTS*MAX_BURST | Pending bits, same layout |
| mem_done_o | output | NUM_SLOTS*MAX_BURST | Done bits, same layout |
| release_en_o | output | 2**IID_W | Release flag per internal identifier |
| released_iid_i | input | 2**IID_W | One-hot release notice |

## Verification
The slot vectors change one edge after an address, beat or done report. A slot is freed and its release flag set one edge after its done bits fill, so two edges after the last done report. A release flag clears one edge after the notice. `aw_ready_o` and `qry_addr_o` respond in the same cycle. The bench drives inputs on the falling edge and updates its queue-based model on the rising edge. It compares every output, and the fixed directed cases, on the next falling edge, so each result is read in the cycle it is due.

// File: rtl/wst_pkg.sv
package wst_pkg;

  // Beats credited at allocation: the balance including this cycle's beat, clamped to 0..len
  function automatic int clamp_imm(input int bal, input int len);
    if (bal <= 0) return 0;
    if (bal >= len) return len;
    return bal;
  endfunction

  // Byte offset of a beat inside an incrementing burst
  function automatic int beat_offset(input int beat, input int size);
    return beat << size;
  endfunction

endpackage

// File: rtl/wst_adv_counter.sv
module wst_adv_counter #(
  parameter int CNT_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             w_valid_i,
  input  logic             aw_fire_i,
  input  logic [LEN_W-1:0] aw_len_i,
  output logic             route_o,
  output logic [LEN_W-1:0] imm_o
);
  localparam logic signed [CNT_W-1:0] CntMax = {1'b0, {(CNT_W-1){1'b1}}};

  logic signed [CNT_W-1:0] bal_q, bal_w, len_s;

  assign len_s   = $signed(CNT_W'(aw_len_i));
  assign bal_w   = bal_q + $signed(CNT_W'(w_valid_i));
  // negative balance: some slot is already waiting for this beat
  assign route_o = w_valid_i & bal_q[CNT_W-1];
  assign imm_o   = LEN_W'(wst_pkg::clamp_imm(int'(bal_w), int'(aw_len_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        bal_q <= '0;
    else if (aw_fire_i) bal_q <= bal_w - len_s;
    else                bal_q <= bal_w;
  end

  AST_BAL_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(w_valid_i && !aw_fire_i && bal_q == CntMax)); // R3

endmodule

// File: rtl/wst_age_matrix.sv
module wst_age_matrix #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_oh_i,
  input  logic [N-1:0] cand_i,
  output logic [N-1:0] oldest_o
);
  localparam int PAIRS = N * (N - 1) / 2;

  // bit for pair (i<j) is 1 when slot j is older than slot i
  logic [PAIRS-1:0] upper_q;

  function automatic int pidx(input int i, input int j);
    return i * N - (i * (i + 1)) / 2 + (j - i - 1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upper_q <= '0;
    else begin
      for (int i = 0; i < N; i++) begin
        for (int j = i + 1; j < N; j++) begin
          if (alloc_oh_i[i])      upper_q[pidx(i, j)] <= 1'b1;
          else if (alloc_oh_i[j]) upper_q[pidx(i, j)] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      oldest_o[i] = cand_i[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && cand_i[j]) begin
          if (j > i ? upper_q[pidx(i, j)] : !upper_q[pidx(j, i)]) oldest_o[i] = 1'b0;
        end
      end
    end
  end

  AST_SINGLE_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cand_i) |-> ($countones(oldest_o) == 1)); // R6

endmodule

// File: rtl/wst_release_flags.sv
module wst_release_flags #(
  parameter int NI = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NI-1:0] set_i,
  input  logic [NI-1:0] clr_i,
  output logic [NI-1:0] flags_o
);
  logic [NI-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= set_i | (flags_q & ~clr_i);
  end

  assign flags_o = flags_q;

  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_i)); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R8
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i)) |=> ((flags_q & $past(clr_i & ~set_i)) == '0)); // R9

endmodule

// File: rtl/wr_slot_tracker.sv
module wr_slot_tracker #(
  parameter int NUM_SLOTS = 4,
  parameter int MAX_BURST = 4,
  parameter int IID_W     = 2,
  parameter int ADDR_W    = 16,
  parameter int SIZE_W    = 3,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BEAT_W   = (MAX_BURST > 1) ? $clog2(MAX_BURST) : 1,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int NUM_IIDS = 1 << IID_W,
  localparam int NB       = NUM_SLOTS * MAX_BURST
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                aw_valid_i,
  output logic                aw_ready_o,
  input  logic [IID_W-1:0]    aw_iid_i,
  input  logic [ADDR_W-1:0]   aw_addr_i,
  input  logic [SIZE_W-1:0]   aw_size_i,
  input  logic                aw_fixed_i,
  input  logic [LEN_W-1:0]    aw_len_i,
  input  logic                w_valid_i,
  output logic                w_ready_o,
  input  logic                done_valid_i,
  input  logic [SLOT_W-1:0]   done_slot_i,
  input  logic [BEAT_W-1:0]   done_beat_i,
  input  logic [SLOT_W-1:0]   qry_slot_i,
  input  logic [BEAT_W-1:0]   qry_beat_i,
  output logic [ADDR_W-1:0]   qry_addr_o,
  output logic [NUM_SLOTS-1:0] slot_valid_o,
  output logic [NB-1:0]       data_v_o,
  output logic [NB-1:0]       pending_o,
  output logic [NB-1:0]       mem_done_o,
  output logic [NUM_IIDS-1:0] release_en_o,
  input  logic [NUM_IIDS-1:0] released_iid_i
);
  typedef logic [MAX_BURST-1:0] beats_t;

  logic [NUM_SLOTS-1:0] valid_q;
  logic [IID_W-1:0]     iid_q   [NUM_SLOTS];
  logic [ADDR_W-1:0]    addr_q  [NUM_SLOTS];
  logic [SIZE_W-1:0]    size_q  [NUM_SLOTS];
  logic                 fixed_q [NUM_SLOTS];
  beats_t               data_v_q[NUM_SLOTS];
  beats_t               pend_q  [NUM_SLOTS];
  beats_t               done_q  [NUM_SLOTS];

  // named internal events
  logic                 aw_fire;
  logic [NUM_SLOTS-1:0] alloc_oh;
  logic [NUM_SLOTS-1:0] cand;
  logic [NUM_SLOTS-1:0] oldest;
  logic [NUM_SLOTS-1:0] complete;
  logic                 route;
  logic                 done_acc;
  logic [LEN_W-1:0]     imm;
  beats_t               fill    [NUM_SLOTS];
  beats_t               done_hit[NUM_SLOTS];
  logic [NUM_IIDS-1:0]  rel_set;
  logic [$clog2(NB)-1:0] done_flat;

  function automatic beats_t init_data(input int len, input int credited);
    beats_t r;
    for (int b = 0; b < MAX_BURST; b++) r[b] = (b < credited) || (b >= len);
    return r;
  endfunction

  function automatic beats_t beyond_burst(input int len);
    beats_t r;
    for (int b = 0; b < MAX_BURST; b++) r[b] = (b >= len);
    return r;
  endfunction

  function automatic beats_t lowest_clear(input beats_t v);
    return ~v & (v + beats_t'(1));
  endfunction

  assign w_ready_o  = 1'b1;
  assign aw_ready_o = ~&valid_q;
  assign aw_fire    = aw_valid_i & aw_ready_o;
  assign done_acc   = done_valid_i & valid_q[done_slot_i] & data_v_q[done_slot_i][done_beat_i];
  assign done_flat  = $clog2(NB)'(int'(done_slot_i) * MAX_BURST + int'(done_beat_i));

  always_comb begin
    alloc_oh = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (!valid_q[s]) alloc_oh = NUM_SLOTS'(1) << s;
    end
  end

  always_comb begin
    rel_set = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      cand[s]     = valid_q[s] & ~&data_v_q[s];
      complete[s] = valid_q[s] & &done_q[s];
      fill[s]     = (route && oldest[s]) ? lowest_clear(data_v_q[s]) : '0;
      done_hit[s] = (done_acc && done_slot_i == SLOT_W'(s)) ? (beats_t'(1) << done_beat_i) : '0;
      if (complete[s]) rel_set[iid_q[s]] = 1'b1;
    end
  end

  wst_adv_counter #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_bal (
    .clk_i(clk_i), .rst_ni(rst_ni), .w_valid_i(w_valid_i), .aw_fire_i(aw_fire),
    .aw_len_i(aw_len_i), .route_o(route), .imm_o(imm)
  );

  wst_age_matrix #(.N(NUM_SLOTS)) u_age (
    .clk_i(clk_i), .rst_ni(rst_ni), .alloc_oh_i(aw_fire ? alloc_oh : '0),
    .cand_i(cand), .oldest_o(oldest)
  );

  wst_release_flags #(.NI(NUM_IIDS)) u_rel (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(rel_set), .clr_i(released_iid_i),
    .flags_o(release_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        iid_q[s]    <= '0;
        addr_q[s]   <= '0;
        size_q[s]   <= '0;
        fixed_q[s]  <= 1'b0;
        data_v_q[s] <= '0;
        pend_q[s]   <= '0;
        done_q[s]   <= '0;
      end
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (aw_fire && alloc_oh[s]) begin
          valid_q[s]  <= 1'b1;
          iid_q[s]    <= aw_iid_i;
          addr_q[s]   <= aw_addr_i;
          size_q[s]   <= aw_size_i;
          fixed_q[s]  <= aw_fixed_i;
          data_v_q[s] <= init_data(int'(aw_len_i), int'(imm));
          pend_q[s]   <= '0;
          done_q[s]   <= beyond_burst(int'(aw_len_i));
        end else if (complete[s]) begin
          valid_q[s]  <= 1'b0;
        end else begin
          data_v_q[s] <= data_v_q[s] | fill[s];
          pend_q[s]   <= (pend_q[s] | fill[s]) & ~done_hit[s];
          done_q[s]   <= done_q[s] | done_hit[s];
        end
      end
    end
  end

  always_comb begin
    slot_valid_o = valid_q;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      data_v_o[s*MAX_BURST +: MAX_BURST]   = data_v_q[s];
      pending_o[s*MAX_BURST +: MAX_BURST]  = pend_q[s];
      mem_done_o[s*MAX_BURST +: MAX_BURST] = done_q[s];
    end
  end

  assign qry_addr_o = fixed_q[qry_slot_i] ? addr_q[qry_slot_i]
                    : addr_q[qry_slot_i] + ADDR_W'(wst_pkg::beat_offset(int'(qry_beat_i),
                                                                        int'(size_q[qry_slot_i])));

  AST_LEN_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_valid_i |-> (aw_len_i != '0 && int'(aw_len_i) <= MAX_BURST)); // R3
  AST_ALLOC_TAKES_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aw_fire |=> ((valid_q & $past(alloc_oh)) == $past(alloc_oh))); // R2
  AST_ROUTE_HAS_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    route |-> (|cand)); // R5
  AST_DONE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_acc |=> mem_done_o[$past(done_flat)]); // R7
  AST_FREE_AFTER_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|complete) |=> ((valid_q & $past(complete)) == '0)); // R8

endmodule

// File: tb/tb_wr_slot_tracker.sv
`timescale 1ns/1ps
module tb_wr_slot_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        aw_valid, aw_ready, aw_fixed, w_valid, w_ready, done_valid;
  logic [1:0]  aw_iid, done_slot, done_beat, qry_slot, qry_beat;
  logic [15:0] aw_addr, qry_addr;
  logic [2:0]  aw_size, aw_len;
  logic [3:0]  slot_valid, release_en, released;
  logic [15:0] data_v, pending, mem_done;

  wr_slot_tracker dut (
    .clk_i(clk), .rst_ni(rst_n), .aw_valid_i(aw_valid), .aw_ready_o(aw_ready),
    .aw_iid_i(aw_iid), .aw_addr_i(aw_addr), .aw_size_i(aw_size), .aw_fixed_i(aw_fixed),
    .aw_len_i(aw_len), .w_valid_i(w_valid), .w_ready_o(w_ready),
    .done_valid_i(done_valid), .done_slot_i(done_slot), .done_beat_i(done_beat),
    .qry_slot_i(qry_slot), .qry_beat_i(qry_beat), .qry_addr_o(qry_addr),
    .slot_valid_o(slot_valid), .data_v_o(data_v), .pending_o(pending),
    .mem_done_o(mem_done), .release_en_o(release_en), .released_iid_i(released)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // behavioural reference
  bit m_valid[4];
  int m_iid[4], m_addr[4], m_size[4];
  bit m_fixed[4];
  bit m_dv[4][4], m_pd[4][4], m_dn[4][4];
  bit m_rel[4];
  int m_bal;
  int age[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 4; s++) begin
      m_valid[s] = 0; m_iid[s] = 0; m_addr[s] = 0; m_size[s] = 0; m_fixed[s] = 0;
      for (int b = 0; b < 4; b++) begin m_dv[s][b] = 0; m_pd[s][b] = 0; m_dn[s][b] = 0; end
    end
    for (int k = 0; k < 4; k++) m_rel[k] = 0;
    m_bal = 0;
    age.delete();
  endtask

  task automatic model_step();
    bit fin[4];
    int afree;
    int bw;
    afree = -1;
    for (int s = 3; s >= 0; s--) if (!m_valid[s]) afree = s;
    for (int s = 0; s < 4; s++)
      fin[s] = m_valid[s] && m_dn[s][0] && m_dn[s][1] && m_dn[s][2] && m_dn[s][3];
    bw = m_bal + (w_valid ? 1 : 0);
    if (done_valid && m_valid[done_slot] && m_dv[done_slot][done_beat]) begin
      m_dn[done_slot][done_beat] = 1;
      m_pd[done_slot][done_beat] = 0;
    end
    if (w_valid && m_bal < 0) begin
      foreach (age[k]) begin
        int t;
        int lb;
        t = age[k];
        lb = -1;
        for (int b = 3; b >= 0; b--) if (!m_dv[t][b]) lb = b;
        if (m_valid[t] && lb >= 0) begin
          m_dv[t][lb] = 1; m_pd[t][lb] = 1;
          break;
        end
      end
    end
    for (int k = 0; k < 4; k++) if (released[k]) m_rel[k] = 0;
    for (int s = 0; s < 4; s++) if (fin[s]) begin
      m_rel[m_iid[s]] = 1;
      m_valid[s] = 0;
      foreach (age[k]) if (age[k] == s) begin age.delete(k); break; end
    end
    if (aw_valid && afree >= 0) begin
      int imm;
      int len;
      len = aw_len;
      imm = (bw <= 0) ? 0 : ((bw >= len) ? len : bw);
      m_valid[afree] = 1; m_iid[afree] = aw_iid; m_addr[afree] = aw_addr;
      m_size[afree] = aw_size; m_fixed[afree] = aw_fixed;
      for (int b = 0; b < 4; b++) begin
        m_dv[afree][b] = (b < imm) || (b >= len);
        m_dn[afree][b] = (b >= len);
        m_pd[afree][b] = 0;
      end
      age.push_back(afree);
      m_bal = bw - len;
    end else begin
      m_bal = bw;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  task automatic compare_all();
    logic [3:0] ev, er;
    logic [15:0] edv, epd, edn;
    int eq;
    for (int s = 0; s < 4; s++) begin
      ev[s] = m_valid[s]; er[s] = m_rel[s];
      for (int b = 0; b < 4; b++) begin
        edv[s*4+b] = m_dv[s][b]; epd[s*4+b] = m_pd[s][b]; edn[s*4+b] = m_dn[s][b];
      end
    end
    eq = m_fixed[qry_slot] ? m_addr[qry_slot]
                           : (m_addr[qry_slot] + qry_beat * (1 << m_size[qry_slot])) % 65536;
    check("R1 w_ready", 32'(w_ready), 32'd1);
    check("R2 aw_ready", 32'(aw_ready), 32'(age.size() < 4));
    check("R2 slot_valid", 32'(slot_valid), 32'(ev));
    check("R3 data_v", 32'(data_v), 32'(edv));
    check("R5 pending", 32'(pending), 32'(epd));
    check("R7 mem_done", 32'(mem_done), 32'(edn));
    check("R9 release_en", 32'(release_en), 32'(er));
    check("R10 qry_addr", 32'(qry_addr), 32'(eq[15:0]));
  endtask

  task automatic idle();
    aw_valid = 0; aw_iid = 0; aw_addr = 0; aw_size = 0; aw_fixed = 0; aw_len = 3'd1;
    w_valid = 0; done_valid = 0; done_slot = 0; done_beat = 0;
    qry_slot = 0; qry_beat = 0; released = 0;
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare_all();
  endtask

  task automatic aw(input int len, input int addr, input int size, input bit fixed, input int iid);
    aw_valid = 1; aw_len = 3'(len); aw_addr = 16'(addr); aw_size = 3'(size);
    aw_fixed = fixed; aw_iid = 2'(iid);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R11 reset state
    check("R11 reset slot_valid", 32'(slot_valid), 32'd0);
    check("R11 reset release_en", 32'(release_en), 32'd0);
    check("R2 reset aw_ready", 32'(aw_ready), 32'd1);
    check("R1 w_ready", 32'(w_ready), 32'd1);

    idle(); w_valid = 1; step();
    idle(); w_valid = 1; step();
    idle(); aw(4, 'h100, 2, 0, 1); step();
    check("R3 early beats credited", 32'(data_v[3:0]), 32'b0011);
    check("R4 in-burst done clear", 32'(mem_done[3:0]), 32'b0000);
    check("R4 pending clear", 32'(pending[3:0]), 32'b0000);
    idle(); aw(2, 'h200, 1, 0, 2); step();
    check("R4 beyond-burst data set", 32'(data_v[7:4]), 32'b1100);
    check("R4 beyond-burst done set", 32'(mem_done[7:4]), 32'b1100);
    idle(); w_valid = 1; step();
    check("R5 late beat to lowest clear bit", 32'(data_v[3:0]), 32'b0111);
    check("R5 pending set", 32'(pending[3:0]), 32'b0100);
    idle(); w_valid = 1; step();
    idle(); w_valid = 1; step();
    check("R6 next oldest slot served", 32'(data_v[7:4]), 32'b1101);
    check("R6 first slot full", 32'(data_v[3:0]), 32'b1111);
    idle(); qry_slot = 1; qry_beat = 1; done_valid = 1; done_slot = 1; done_beat = 1; step();
    check("R7 done without data ignored", 32'(mem_done[7:4]), 32'b1100);
    check("R10 incrementing beat address", 32'(qry_addr), 32'h0202);
    idle(); w_valid = 1; done_valid = 1; done_slot = 1; done_beat = 0; step();
    check("R7 done taken", 32'(mem_done[7:4]), 32'b1101);
    check("R7 pending cleared", 32'(pending[7:4]), 32'b0010);
    idle(); done_valid = 1; done_slot = 1; done_beat = 1; step();
    check("R8 not yet freed", 32'(slot_valid), 32'b0011);
    idle(); step();
    check("R8 slot freed", 32'(slot_valid), 32'b0001);
    check("R8 release flag set", 32'(release_en), 32'b0100);
    idle(); released = 4'b0100; step();
    check("R9 release flag cleared", 32'(release_en), 32'b0000);
    idle(); aw(1, 'h300, 3, 1, 3); step();
    check("R2 lowest free slot", 32'(slot_valid), 32'b0011);
    idle(); aw(1, 'h400, 0, 0, 0); qry_slot = 1; qry_beat = 2; step();
    check("R10 fixed beat address", 32'(qry_addr), 32'h0300);
    idle(); aw(1, 'h500, 0, 0, 1); step();
    check("R2 full", 32'(aw_ready), 32'd0);
    idle(); aw(2, 'h600, 0, 0, 2); step();
    check("R2 full request ignored", 32'(slot_valid), 32'b1111);

    for (int c = 0; c < 4000; c++) begin
      idle();
      if ($urandom % 3 == 0) aw(1 + $urandom % 4, $urandom, $urandom % 4, ($urandom % 4) == 0, $urandom % 4);
      w_valid = (m_bal < 12) && ($urandom % 2 == 0);
      done_valid = ($urandom % 2 == 0);
      done_slot = 2'($urandom); done_beat = 2'($urandom);
      qry_slot = 2'($urandom); qry_beat = 2'($urandom);
      if ($urandom % 5 == 0) released = 4'b0001 << ($urandom % 4);
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(190000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule